// File: doc/BRIEF.md
# Paged Outbound Address Translator

This block converts addresses from an on-chip 32-bit memory-mapped bus into 64-bit PCIe addresses. The local address range is cut into equal pages. A field of the local address selects one page entry from a small table. That entry supplies the upper bits of the PCIe address. The offset within the page is copied through without change.

Software writes the table through a 32-bit control slave port. The table occupies a fixed window in the control register space, and each entry is stored as two 32-bit words. A lookup is registered. Its result appears one cycle after the request, together with a valid strobe.

With the default parameters there are 16 pages of 1 MByte each. The page offset is therefore 20 bits wide, and local bits [23:20] select the entry. Local bits [31:24] are used by the interconnect to select this slave, and the translation ignores them.

Top module: `pcie_addr_xlate`

## Requirements
- R1: After reset every table entry is zero, `xl_valid` and `csr_rvalid` are low, and a lookup returns only the passed-through page offset.
- R2: `xl_valid` is high in exactly the cycle after a cycle with `xl_req` high, and low in every other cycle.
- R3: PCIe address bits [19:0] equal local address bits [19:0] of the request.
- R4: Local address bits [23:20] select entry i. PCIe address bits [63:20] are bits [63:20] of entry i.
- R5: Local address bits [31:24] have no effect on the translated address.
- R6: The word at control byte address 0x1000 + 8*i holds entry bits [31:20] in data bits [31:20]. Its bits [19:0] read as zero and are ignored on write.
- R7: The word at control byte address 0x1000 + 8*i + 4 holds entry bits [63:32] in data bits [31:0].
- R8: A read presents `csr_rdata` with `csr_rvalid` high in the following cycle. Reads outside the window 0x1000 to 0x107F return zero, and writes outside that window change no entry.
- R9: A lookup issued in the same cycle as a write to its entry returns the entry's old value. A lookup issued in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_write | input | 1 | Control write strobe |
| csr_read | input | 1 | Control read strobe |
| csr_addr | input | 13 | Control byte address |
| csr_wdata | input | 32 | Control write data |
| csr_rdata | output | 32 | Control read data, registered |
| csr_rvalid | output | 1 | Read data valid, one cycle after `csr_read` |
| xl_req | input | 1 | Translation request |
| xl_addr | input | 32 | Local bus address to translate |
| xl_valid | output | 1 | Translated address valid |
| xl_pcie_addr | output | 64 | Translated 64-bit PCIe address |

## Verification
The assertions assume that a control access is word-aligned and that `csr_read` and `csr_write` are never high in the same cycle. They also assume that `xl_addr` is only meaningful while `xl_req` is high. The bench keeps to these conditions in three ways. It drives every strobe for a single cycle on the falling edge. It uses only word-aligned control addresses. It never combines a read with a write, though it does pair a write with a lookup on purpose to test the ordering between them.

// File: rtl/pcie_addr_xlate.sv
module pcie_addr_xlate #(
  parameter int NUM_PAGES  = 16,
  parameter int PAGE_BITS  = 20,
  parameter int LOCAL_AW   = 32,
  parameter int PCIE_AW    = 64,
  parameter int CSR_AW     = 13,
  parameter int TABLE_BASE = 'h1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_write,
  input  logic                csr_read,
  input  logic [CSR_AW-1:0]   csr_addr,
  input  logic [31:0]         csr_wdata,
  output logic [31:0]         csr_rdata,
  output logic                csr_rvalid,
  input  logic                xl_req,
  input  logic [LOCAL_AW-1:0] xl_addr,
  output logic                xl_valid,
  output logic [PCIE_AW-1:0]  xl_pcie_addr
);
  localparam int IDX_BITS  = $clog2(NUM_PAGES);
  localparam int HI_BITS   = PCIE_AW - PAGE_BITS;
  localparam int LO_KEEP   = 32 - PAGE_BITS;
  localparam int WIN_BYTES = NUM_PAGES * 8;

  logic [HI_BITS-1:0] tbl [NUM_PAGES];

  wire [CSR_AW-1:0]   win_off  = csr_addr - CSR_AW'(TABLE_BASE);
  wire                in_win   = (csr_addr >= CSR_AW'(TABLE_BASE)) && (win_off < CSR_AW'(WIN_BYTES));
  wire [IDX_BITS-1:0] csr_sel  = win_off[IDX_BITS+2:3];
  wire                hi_word  = win_off[2];
  wire [IDX_BITS-1:0] xl_sel   = xl_addr[PAGE_BITS+IDX_BITS-1:PAGE_BITS];

  wire unused_ok = &{1'b0, csr_wdata[PAGE_BITS-1:0], xl_addr[LOCAL_AW-1:PAGE_BITS+IDX_BITS]};

  wire [31:0] rd_word = !in_win ? 32'd0 :
                        hi_word ? tbl[csr_sel][HI_BITS-1:LO_KEEP] :
                                  {tbl[csr_sel][LO_KEEP-1:0], PAGE_BITS'(0)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PAGES; i++) tbl[i] <= '0;
    end else if (csr_write && in_win) begin
      if (hi_word) tbl[csr_sel][HI_BITS-1:LO_KEEP] <= csr_wdata;
      else         tbl[csr_sel][LO_KEEP-1:0]       <= csr_wdata[31:PAGE_BITS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_rvalid   <= 1'b0;
      csr_rdata    <= '0;
      xl_valid     <= 1'b0;
      xl_pcie_addr <= '0;
    end else begin
      csr_rvalid <= csr_read;
      if (csr_read) csr_rdata <= rd_word;
      xl_valid <= xl_req;
      if (xl_req) xl_pcie_addr <= {tbl[xl_sel], xl_addr[PAGE_BITS-1:0]};
    end
  end
endmodule

// File: rtl/pcie_addr_xlate_chk.sv
module pcie_addr_xlate_chk #(
  parameter int PAGE_BITS = 20,
  parameter int LOCAL_AW  = 32,
  parameter int PCIE_AW   = 64,
  parameter int CSR_AW    = 13
) (
  input logic                clk,
  input logic                rst_n,
  input logic                csr_read,
  input logic [CSR_AW-1:0]   csr_addr,
  input logic [31:0]         csr_rdata,
  input logic                csr_rvalid,
  input logic                xl_req,
  input logic [LOCAL_AW-1:0] xl_addr,
  input logic                xl_valid,
  input logic [PCIE_AW-1:0]  xl_pcie_addr
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) xl_req |=> xl_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !xl_req |=> !xl_valid); // R2
  AST_OFFSET_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> xl_pcie_addr[PAGE_BITS-1:0] == $past(xl_addr[PAGE_BITS-1:0])); // R3
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) csr_read |=> csr_rvalid); // R8
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n) !csr_read |=> !csr_rvalid); // R8
  AST_LOW_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_read && !csr_addr[2]) |=> csr_rdata[PAGE_BITS-1:0] == '0); // R6
endmodule

bind pcie_addr_xlate pcie_addr_xlate_chk #(
  .PAGE_BITS(PAGE_BITS), .LOCAL_AW(LOCAL_AW), .PCIE_AW(PCIE_AW), .CSR_AW(CSR_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_read(csr_read), .csr_addr(csr_addr),
  .csr_rdata(csr_rdata), .csr_rvalid(csr_rvalid), .xl_req(xl_req),
  .xl_addr(xl_addr), .xl_valid(xl_valid), .xl_pcie_addr(xl_pcie_addr)
);

// File: tb/pcie_addr_xlate_tb.sv
module pcie_addr_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_write = 1'b0, csr_read = 1'b0;
  logic [12:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_rvalid;
  logic        xl_req = 1'b0;
  logic [31:0] xl_addr = '0;
  logic        xl_valid;
  logic [63:0] xl_pcie_addr;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pcie_addr_xlate u_dut (.*);

  // {local address, expected PCIe address} after table programming
  localparam logic [95:0] VEC [6] = '{
    {32'h0031_2345, 64'hA000_0003_35C1_2345},  // R4
    {32'hFF31_2345, 64'hA000_0003_35C1_2345},  // R5
    {32'h0000_0000, 64'hA000_0000_05C0_0000},  // R4
    {32'h00FF_FFFF, 64'hA000_000F_F5CF_FFFF},  // R3
    {32'h5A7A_BCDE, 64'hA000_0007_75CA_BCDE},  // R5
    {32'h01A0_0001, 64'hA000_000A_A5C0_0001}   // R4
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); csr_write = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_write = 1'b0;
  endtask

  task automatic csr_rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk); csr_read = 1'b1; csr_addr = a;
    @(negedge clk); csr_read = 1'b0;
    chk("R8 rvalid", 64'(csr_rvalid), 64'd1);
    d = csr_rdata;
  endtask

  task automatic xlate(input logic [31:0] a, output logic [63:0] r);
    @(negedge clk); xl_req = 1'b1; xl_addr = a;
    @(negedge clk); xl_req = 1'b0;
    chk("R2 valid", 64'(xl_valid), 64'd1);
    r = xl_pcie_addr;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] r;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R1 xl_valid", 64'(xl_valid), 64'd0);
    chk("R1 csr_rvalid", 64'(csr_rvalid), 64'd0);
    rst_n = 1'b1;
    xlate(32'h0051_2345, r);
    chk("R1 zero entry", r, 64'h0000_0000_0001_2345);
    @(negedge clk);
    chk("R2 no valid without req", 64'(xl_valid), 64'd0);

    for (int i = 0; i < 16; i++) begin
      csr_wr(13'h1000 + 13'(i * 8), {4'(i), 8'h5C, 20'hFFFFF});
      csr_wr(13'h1004 + 13'(i * 8), 32'hA000_0000 | 32'(i));
    end

    csr_rd(13'h1010, d);
    chk("R6 low word", 64'(d), 64'h25C0_0000);
    csr_rd(13'h1014, d);
    chk("R7 high word", 64'(d), 64'hA000_0002);

    for (int k = 0; k < 6; k++) begin
      xlate(VEC[k][95:64], r);
      chk("R4/R5 vector", r, VEC[k][63:0]);
    end

    csr_rd(13'h0FFC, d);
    chk("R8 below window", 64'(d), 64'd0);
    csr_rd(13'h1080, d);
    chk("R8 above window", 64'(d), 64'd0);
    csr_wr(13'h1080, 32'hDEAD_BEEF);
    csr_wr(13'h0FF8, 32'hDEAD_BEEF);
    csr_rd(13'h1000, d);
    chk("R8 write outside ignored", 64'(d), 64'h05C0_0000);
    csr_rd(13'h1078, d);
    chk("R8 write outside ignored", 64'(d), 64'hF5C0_0000);

    @(negedge clk);
    csr_write = 1'b1; csr_addr = 13'h1024; csr_wdata = 32'hB000_0004;
    xl_req = 1'b1; xl_addr = 32'h0040_0010;
    @(negedge clk);
    csr_write = 1'b0; xl_req = 1'b0;
    chk("R9 old value", xl_pcie_addr, 64'hA000_0004_45C0_0010);
    xlate(32'h0040_0010, r);
    chk("R9 new value", r, 64'hB000_0004_45C0_0010);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule